// File: doc/BRIEF.md
# Per-Master Aperture Address Decoder

This block sits at the address stage of a multi-master memory interconnect. Each master has its own small table. The table splits the 32-bit address space into sixteen equal apertures, selected by the top address nibble. For each aperture the table holds a 4-bit destination code and a 4-bit replacement nibble. For every transaction the decoder reports the destination code and the remapped address, and it flags a decode error when the selected code names no valid destination.

The tables are programmed through a word-wide write port and can be read back through a combinational read port. Writes land in shadow words. The shadow words only take effect when software writes the value 1 to that master's update register. If the master still has transactions outstanding, the commit waits until they have all completed. Master 0 also has a boot-mirror control. While that control is set, aperture 0 goes to the ROM untranslated, whatever the table holds.

Top module: `axi_aperture_map`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every master's shadow and active tables hold the defaults: select words 0x11111111 and 0x11111111, offset words 0xFEDCBA98 and 0x76543210. Master 0's boot control reads 1.
- R2: A request presented in one cycle yields `rsp_valid` in the next cycle. The aperture is n = `req_addr[31:28]`. The destination is nibble n of the 64-bit value {select word 0, select word 1}, and the output address is nibble n of {offset word 0, offset word 1} followed by `req_addr[27:0]` unchanged.
- R3: The register bank of master m is at byte address m*0x20. Select word 0 is at +0x00, select word 1 at +0x04, offset word 0 at +0x08 and offset word 1 at +0x0C. A write changes the value read back at once, but it does not change decoding until a commit.
- R4: Writing exactly 1 to +0x14 commits all four shadow words of that master into its active table. A write of any other value to +0x14 commits nothing.
- R5: A master's outstanding count is raised by each of its requests and lowered by each of its `done_valid` pulses. An update written while the count is nonzero stays pending. It commits on the first clock edge at which the count is zero.
- R6: Destination code 0, any code above 10, or a `req_mst` of 12 or more gives `rsp_err` = 1 with `rsp_slave` = 0. The codes are: 1 DDR port 1, 2 SRAM, 3 tunnel, 4 external bus, 5 ROM, 6 APB bridge, 7 DDR port 2, 8 DDR port 3, 9 coherency port, 10 direct memory port.
- R7: Master 0 has a boot control at +0x10, bits [1:0], which takes effect immediately. While it is nonzero, aperture 0 of master 0 decodes to code 5 with the address unchanged and no error. Other masters have no boot control: +0x10 reads 0 and writes to it do nothing.
- R8: Writes and commits to one master leave every other master's tables and decoding unchanged.
- R9: Reads of +0x14, +0x18 and +0x1C return 0. Reads and writes whose address bits [1:0] are nonzero return 0 and are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 9 | Register write byte address |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_addr | input | 9 | Register read byte address |
| cfg_rd_data | output | 32 | Shadow value at the read address |
| req_valid | input | 1 | Transaction address present |
| req_mst | input | 4 | Issuing master index |
| req_addr | input | 32 | Transaction address |
| done_valid | input | 1 | A transaction has completed |
| done_mst | input | 4 | Master whose transaction completed |
| rsp_valid | output | 1 | Decode result valid |
| rsp_slave | output | 4 | Destination code |
| rsp_addr | output | 32 | Remapped address |
| rsp_err | output | 1 | Decode error |

## Verification
The hardest case to reach is an update that is held back by traffic in flight. The bench opens two transactions for one master and writes the update between them, then shows that the second transaction still decodes with the old table. It then retires both transactions and waits one idle cycle before the next request, which must decode with the new table. The boot mirror is also checked while a committed table routes aperture 0 elsewhere, so that clearing the control visibly changes both the destination and the address.

// File: rtl/apmap_pkg.sv
package apmap_pkg;
    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int NIB    = 4;
    localparam int N_APT  = 16;
    localparam int TBL_W  = N_APT * NIB;
    localparam int BANK_B = 32;

    // word index within a bank (byte offset / 4)
    localparam logic [2:0] W_SEL0 = 3'd0;
    localparam logic [2:0] W_SEL1 = 3'd1;
    localparam logic [2:0] W_OFS0 = 3'd2;
    localparam logic [2:0] W_OFS1 = 3'd3;
    localparam logic [2:0] W_BOOT = 3'd4;
    localparam logic [2:0] W_UPD  = 3'd5;

    typedef enum logic [NIB-1:0] {
        DST_NONE   = 4'd0,
        DST_DDR_A  = 4'd1,
        DST_SRAM   = 4'd2,
        DST_TUNNEL = 4'd3,
        DST_EXTBUS = 4'd4,
        DST_ROM    = 4'd5,
        DST_APB    = 4'd6,
        DST_DDR_B  = 4'd7,
        DST_DDR_C  = 4'd8,
        DST_COHER  = 4'd9,
        DST_DIRECT = 4'd10
    } dest_e;

    typedef struct packed {
        logic          valid;
        logic          err;
        logic [NIB-1:0] slave;
        logic [AW-1:0] addr;
    } rsp_t;
endpackage

// File: rtl/apmap_xlate.sv
module apmap_xlate
    import apmap_pkg::*;
(
    input  logic [TBL_W-1:0] sel_tbl,
    input  logic [TBL_W-1:0] ofs_tbl,
    input  logic             boot_on,
    input  logic [AW-1:0]    addr_in,
    output logic [NIB-1:0]   slave,
    output logic [AW-1:0]    addr_out,
    output logic             err
);
    localparam int HI = AW - NIB;

    logic [NIB-1:0] apt;
    logic [NIB-1:0] code;
    logic [NIB-1:0] ofs;

    always_comb begin
        apt  = addr_in[AW-1:HI];
        code = sel_tbl[apt*NIB +: NIB];
        ofs  = ofs_tbl[apt*NIB +: NIB];
        if (boot_on && apt == '0) begin
            slave    = DST_ROM;
            addr_out = addr_in;
            err      = 1'b0;
        end else begin
            err      = (code == DST_NONE) || (code > DST_DIRECT);
            slave    = err ? NIB'(DST_NONE) : code;
            addr_out = {ofs, addr_in[HI-1:0]};
        end
    end
endmodule

// File: rtl/apmap_bank.sv
module apmap_bank
    import apmap_pkg::*;
#(
    parameter bit          HAS_BOOT = 1'b0,
    parameter int          CNT_W    = 4,
    parameter logic [31:0] DEF_SEL0 = 32'h1111_1111,
    parameter logic [31:0] DEF_SEL1 = 32'h1111_1111,
    parameter logic [31:0] DEF_OFS0 = 32'hFEDC_BA98,
    parameter logic [31:0] DEF_OFS1 = 32'h7654_3210,
    parameter logic [1:0]  DEF_BOOT = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_word,
    input  logic [DW-1:0]    wr_data,
    input  logic [2:0]       rd_word,
    output logic [DW-1:0]    rd_data,
    input  logic             req_hit,
    input  logic             done_hit,
    output logic [TBL_W-1:0] act_sel,
    output logic [TBL_W-1:0] act_ofs,
    output logic             boot_on
);
    typedef struct packed {
        logic [DW-1:0]    sel0;
        logic [DW-1:0]    sel1;
        logic [DW-1:0]    ofs0;
        logic [DW-1:0]    ofs1;
        logic [TBL_W-1:0] asel;
        logic [TBL_W-1:0] aofs;
        logic [1:0]       boot;
        logic             pend;
        logic [CNT_W-1:0] cnt;
    } bank_t;

    bank_t st_q, st_d;
    logic  upd_hit, dec, commit_want;

    always_comb begin
        st_d        = st_q;
        upd_hit     = wr_en && (wr_word == W_UPD) && (wr_data == 32'd1);
        dec         = done_hit && (st_q.cnt != '0);
        commit_want = upd_hit || st_q.pend;

        if (wr_en) begin
            case (wr_word)
                W_SEL0: st_d.sel0 = wr_data;
                W_SEL1: st_d.sel1 = wr_data;
                W_OFS0: st_d.ofs0 = wr_data;
                W_OFS1: st_d.ofs1 = wr_data;
                W_BOOT: if (HAS_BOOT) st_d.boot = wr_data[1:0];
                default: ;
            endcase
        end

        case ({req_hit, dec})
            2'b10: if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
            2'b01: st_d.cnt = st_q.cnt - 1'b1;
            default: ;
        endcase

        if (commit_want) begin
            if (st_q.cnt == '0) begin
                st_d.asel = {st_q.sel0, st_q.sel1};
                st_d.aofs = {st_q.ofs0, st_q.ofs1};
                st_d.pend = 1'b0;
            end else begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel0 <= DEF_SEL0;
            st_q.sel1 <= DEF_SEL1;
            st_q.ofs0 <= DEF_OFS0;
            st_q.ofs1 <= DEF_OFS1;
            st_q.asel <= {DEF_SEL0, DEF_SEL1};
            st_q.aofs <= {DEF_OFS0, DEF_OFS1};
            st_q.boot <= HAS_BOOT ? DEF_BOOT : 2'b00;
            st_q.pend <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_word)
            W_SEL0:  rd_data = st_q.sel0;
            W_SEL1:  rd_data = st_q.sel1;
            W_OFS0:  rd_data = st_q.ofs0;
            W_OFS1:  rd_data = st_q.ofs1;
            W_BOOT:  rd_data = {30'd0, st_q.boot};
            default: rd_data = '0;
        endcase
    end

    assign act_sel = st_q.asel;
    assign act_ofs = st_q.aofs;

    generate
        if (HAS_BOOT) begin : g_boot
            assign boot_on = |st_q.boot;
        end else begin : g_noboot
            assign boot_on = 1'b0;
        end
    endgenerate

    // R5: the active table only moves on an edge where nothing was outstanding
    a_r5_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.asel != $past(st_q.asel) || st_q.aofs != $past(st_q.aofs))
            |-> ($past(st_q.cnt) == '0));

    // R5: a pending update drains as soon as the master is idle
    a_r5_pend_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && st_q.cnt == '0) |=> !st_q.pend);

    // R3: shadow words change only under a write
    a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({st_q.sel0, st_q.sel1, st_q.ofs0, st_q.ofs1}));
endmodule

// File: rtl/axi_aperture_map.sv
module axi_aperture_map
    import apmap_pkg::*;
#(
    parameter int N_MST  = 12,
    parameter int CNT_W  = 4,
    localparam int MST_W = $clog2(N_MST),
    localparam int ADR_W = MST_W + $clog2(BANK_B)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [ADR_W-1:0] cfg_wr_addr,
    input  logic [DW-1:0]    cfg_wr_data,
    input  logic [ADR_W-1:0] cfg_rd_addr,
    output logic [DW-1:0]    cfg_rd_data,
    input  logic             req_valid,
    input  logic [MST_W-1:0] req_mst,
    input  logic [AW-1:0]    req_addr,
    input  logic             done_valid,
    input  logic [MST_W-1:0] done_mst,
    output logic             rsp_valid,
    output logic [NIB-1:0]   rsp_slave,
    output logic [AW-1:0]    rsp_addr,
    output logic             rsp_err
);
    localparam int OFF_W = $clog2(BANK_B);

    logic [MST_W-1:0] wr_idx, rd_idx;
    logic [2:0]       wr_word, rd_word;
    logic             wr_ok, rd_ok, req_ok;

    logic [DW-1:0]    bank_rd  [N_MST];
    logic [TBL_W-1:0] bank_sel [N_MST];
    logic [TBL_W-1:0] bank_ofs [N_MST];
    logic             bank_boot[N_MST];

    assign wr_idx  = cfg_wr_addr[ADR_W-1:OFF_W];
    assign rd_idx  = cfg_rd_addr[ADR_W-1:OFF_W];
    assign wr_word = cfg_wr_addr[OFF_W-1:2];
    assign rd_word = cfg_rd_addr[OFF_W-1:2];
    assign wr_ok   = cfg_wr_en && (cfg_wr_addr[1:0] == 2'b00);
    assign rd_ok   = (cfg_rd_addr[1:0] == 2'b00) &&
                     ({1'b0, rd_idx} < (MST_W+1)'(N_MST));
    assign req_ok  = ({1'b0, req_mst} < (MST_W+1)'(N_MST));

    generate
        for (genvar m = 0; m < N_MST; m++) begin : g_bank
            apmap_bank #(
                .HAS_BOOT (m == 0),
                .CNT_W    (CNT_W)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_ok && wr_idx == MST_W'(m)),
                .wr_word  (wr_word),
                .wr_data  (cfg_wr_data),
                .rd_word  (rd_word),
                .rd_data  (bank_rd[m]),
                .req_hit  (req_valid && req_mst == MST_W'(m)),
                .done_hit (done_valid && done_mst == MST_W'(m)),
                .act_sel  (bank_sel[m]),
                .act_ofs  (bank_ofs[m]),
                .boot_on  (bank_boot[m])
            );
        end
    endgenerate

    assign cfg_rd_data = rd_ok ? bank_rd[rd_idx] : '0;

    logic [TBL_W-1:0] cur_sel, cur_ofs;
    logic             cur_boot;
    logic [NIB-1:0]   x_slave;
    logic [AW-1:0]    x_addr;
    logic             x_err;

    assign cur_sel  = req_ok ? bank_sel[req_mst]  : '0;
    assign cur_ofs  = req_ok ? bank_ofs[req_mst]  : '0;
    assign cur_boot = req_ok ? bank_boot[req_mst] : 1'b0;

    apmap_xlate u_xlate (
        .sel_tbl  (cur_sel),
        .ofs_tbl  (cur_ofs),
        .boot_on  (cur_boot),
        .addr_in  (req_addr),
        .slave    (x_slave),
        .addr_out (x_addr),
        .err      (x_err)
    );

    rsp_t rsp_q, rsp_d;

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.err   = x_err;
            rsp_d.slave = x_slave;
            rsp_d.addr  = x_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_slave = rsp_q.slave;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_err   = rsp_q.err;

    // R2: one response per request, one cycle later
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2: only the top nibble of the address may change
    a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_addr[AW-NIB-1:0] == $past(req_addr[AW-NIB-1:0]));
    // R6: an errored response never names a destination
    a_r6_err_slave: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> rsp_slave == '0);
endmodule

// File: tb/axi_aperture_map_test.sv
module axi_aperture_map_test;
    localparam int CLK_PERIOD = 10;
    localparam int NM = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [8:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [8:0]  cfg_rd_addr = '0;
    logic [31:0] cfg_rd_data;
    logic        req_valid = 1'b0;
    logic [3:0]  req_mst = '0;
    logic [31:0] req_addr = '0;
    logic        done_valid = 1'b0;
    logic [3:0]  done_mst = '0;
    logic        rsp_valid;
    logic [3:0]  rsp_slave;
    logic [31:0] rsp_addr;
    logic        rsp_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [63:0] exp_s [NM];
    logic [63:0] exp_o [NM];
    bit          boot0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axi_aperture_map uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .req_valid(req_valid), .req_mst(req_mst), .req_addr(req_addr),
        .done_valid(done_valid), .done_mst(done_mst),
        .rsp_valid(rsp_valid), .rsp_slave(rsp_slave), .rsp_addr(rsp_addr), .rsp_err(rsp_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [36:0] model(input logic [63:0] s, input logic [63:0] o,
                                          input bit boot, input logic [31:0] a);
        int ap = int'(a[31:28]);
        logic [3:0] code = s[ap*4 +: 4];
        if (boot && ap == 0) return {1'b0, 4'd5, a};
        if (code == 4'd0 || code > 4'd10) return {1'b1, 4'd0, o[ap*4 +: 4], a[27:0]};
        return {1'b0, code, o[ap*4 +: 4], a[27:0]};
    endfunction

    task automatic wr(input logic [8:0] ad, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = ad; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [8:0] ad, input logic [31:0] exp);
        cfg_rd_addr = ad;
        #1;
        check(tag, 64'(cfg_rd_data), 64'(exp));
    endtask

    task automatic retire(input int m);
        @(negedge clk);
        done_valid = 1'b1; done_mst = 4'(m);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic req(input string tag, input int m, input logic [31:0] a, input bit keep);
        logic [36:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_mst = 4'(m); req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (m < NM) e = model(exp_s[m], exp_o[m], (m == 0) && boot0, a);
        else        e = model(64'd0, 64'd0, 1'b0, a);
        check({tag, " valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " route"}, 64'({rsp_err, rsp_slave, rsp_addr}), 64'(e));
        if (!keep && m < NM) retire(m);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid idle", 64'(rsp_valid), 64'd0);
        rd_chk("R1 sel0 default", 9'(5*32 + 0), 32'h1111_1111);
        rd_chk("R1 ofs0 default", 9'(5*32 + 8), 32'hFEDC_BA98);
        rd_chk("R1 ofs1 default", 9'(5*32 + 12), 32'h7654_3210);
        rd_chk("R1 boot default", 9'h010, 32'd1);
    endtask

    task automatic t_identity;
        req("R2 identity m2", 2, 32'h3456_789A, 1'b0);
        req("R2 identity m9 top", 9, 32'hF000_0004, 1'b0);
        @(negedge clk);
        check("R2 valid drops", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_shadow_update;
        wr(9'(4*32 + 0), 32'h7799_9999);
        wr(9'(4*32 + 4), 32'h2345_6789);
        wr(9'(4*32 + 12), 32'h0123_4567);
        rd_chk("R3 shadow readback", 9'(4*32 + 4), 32'h2345_6789);
        req("R3 shadow inert", 4, 32'h1000_0010, 1'b0);
        wr(9'(4*32 + 20), 32'd1);
        exp_s[4] = {32'h7799_9999, 32'h2345_6789};
        exp_o[4] = {32'hFEDC_BA98, 32'h0123_4567};
        req("R4 commit low apt", 4, 32'h1000_0010, 1'b0);
        req("R4 commit high apt", 4, 32'hE000_0004, 1'b0);
        req("R2 remap apt0", 4, 32'h0000_0ABC, 1'b0);
    endtask

    task automatic t_update_value;
        wr(9'(6*32 + 4), 32'h2222_2222);
        wr(9'(6*32 + 20), 32'd2);
        req("R4 update value 2 ignored", 6, 32'h0000_0040, 1'b0);
        wr(9'(6*32 + 21), 32'd1);
        req("R9 unaligned update ignored", 6, 32'h0000_0040, 1'b0);
        wr(9'(6*32 + 20), 32'd1);
        exp_s[6] = {32'h1111_1111, 32'h2222_2222};
        req("R4 update value 1", 6, 32'h0000_0040, 1'b0);
        rd_chk("R9 update reads 0", 9'(6*32 + 20), 32'd0);
        rd_chk("R9 spare word reads 0", 9'(6*32 + 24), 32'd0);
        rd_chk("R9 unaligned read 0", 9'(6*32 + 5), 32'd0);
    endtask

    task automatic t_deferred;
        wr(9'(3*32 + 4), 32'h3333_3333);
        req("R5 before update", 3, 32'h0000_0100, 1'b1);
        wr(9'(3*32 + 20), 32'd1);
        req("R5 held while busy", 3, 32'h0000_0200, 1'b1);
        retire(3);
        retire(3);
        @(negedge clk);
        exp_s[3] = {32'h1111_1111, 32'h3333_3333};
        req("R5 applied after drain", 3, 32'h0000_0300, 1'b0);
    endtask

    task automatic t_errors;
        wr(9'(7*32 + 4), 32'h1111_11B0);
        wr(9'(7*32 + 20), 32'd1);
        exp_s[7] = {32'h1111_1111, 32'h1111_11B0};
        req("R6 code 0", 7, 32'h0123_4567, 1'b0);
        req("R6 code 11", 7, 32'h1000_0000, 1'b0);
        req("R6 valid code", 7, 32'h2000_0000, 1'b0);
        req("R6 master 13", 13, 32'h5000_0000, 1'b0);
    endtask

    task automatic t_boot;
        req("R7 boot at reset", 0, 32'h0ABC_DEF0, 1'b0);
        wr(9'h004, 32'h1111_1112);
        wr(9'h00C, 32'h7654_321C);
        wr(9'h014, 32'd1);
        exp_s[0] = {32'h1111_1111, 32'h1111_1112};
        exp_o[0] = {32'hFEDC_BA98, 32'h7654_321C};
        req("R7 boot overrides table", 0, 32'h0ABC_DEF0, 1'b0);
        req("R7 boot leaves apt1", 0, 32'h1ABC_DEF0, 1'b0);
        wr(9'h010, 32'h0000_0004);
        boot0 = 1'b0;
        rd_chk("R7 boot cleared", 9'h010, 32'd0);
        req("R7 table after boot clear", 0, 32'h0ABC_DEF0, 1'b0);
        wr(9'(5*32 + 16), 32'd3);
        rd_chk("R7 no boot on m5", 9'(5*32 + 16), 32'd0);
        req("R7 m5 apt0 untouched", 5, 32'h0000_0040, 1'b0);
    endtask

    task automatic t_independence;
        req("R8 m5 after m4 change", 5, 32'h1000_0010, 1'b0);
        rd_chk("R8 m5 shadow kept", 9'(5*32 + 4), 32'h1111_1111);
        req("R8 m8 after m7 change", 8, 32'h0123_4567, 1'b0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < NM; m++) begin
            exp_s[m] = {32'h1111_1111, 32'h1111_1111};
            exp_o[m] = {32'hFEDC_BA98, 32'h7654_3210};
        end
        boot0 = 1'b1;
        t_reset();
        t_identity();
        t_shadow_update();
        t_update_value();
        t_deferred();
        t_errors();
        t_boot();
        t_independence();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule